// File: doc/BRIEF.md
# Address Lookup Table Engine

This block holds the address table of a small Ethernet switch. Each entry records one MAC address and how it is handled: a unicast entry names one port and carries secure and blocked flags. A multicast entry carries a port mask and a forward state. Software reaches the table through three 32-bit data words and one table-control register. A table-control write with the write flag set stores the data words into the chosen entry. A table-control write with the flag clear loads the chosen entry into the data words.

A hardware insert command places a unicast or multicast entry without software walking the table. It reads one entry per clock, lowest index first, and then writes the entry it selects. A matching address comes first, then the lowest free slot, then the lowest evictable unicast entry. A multicast insert into a matching entry keeps the ports that entry already had. The block also holds a 2-bit forwarding state for each port. It can wipe the whole table back to free entries, and it does so on its own after reset.

Top module: `addr_lookup_table`

## Requirements
- R1: After reset the data words, the fail flag and every port state read 0. Busy is high for the DEPTH cycles of a wipe and then falls, and every entry then reads all zeros.
- R2: Register select 0, 1 and 2 write data words 0, 1 and 2. Word 0 keeps only its low ENTRY_W-64 bits (5 by default) and holds entry bits 68:64. Word 1 holds bits 63:32 and word 2 holds bits 31:0.
- R3: A table-control write (select 3) names the entry index in its low bits. With bit 31 set it stores the data words into that entry. With bit 31 clear it loads that entry into the data words, which change on the second clock edge after the command.
- R4: Entries use this layout: type in bits 61:60 (0 free, 1 address, 2 VLAN, 3 VLAN and address), MAC in bits 47:0 with bit 40 as the group bit, and the unicast type in bits 63:62 (0 persistent, 1 untouched, 2 OUI, 3 touched). An insert whose MAC equals that of a type 1 or type 3 entry rewrites the lowest such entry.
- R5: With no matching entry, an insert goes to the lowest-indexed entry of type 0.
- R6: With no match and no free entry, an insert goes to the lowest entry of type 1 or 3 that has bit 40 clear and unicast type 1 or 3. OUI, persistent and group entries are never evicted.
- R7: When no entry qualifies, the fail flag rises as busy falls and the table is left unchanged. The next accepted insert clears the fail flag.
- R8: A unicast insert writes type 1 and unicast type 0, with secure in bit 64, blocked in bit 65, the port number in bits 67:66 and bit 68 zero.
- R9: A multicast insert writes type 1 with 3 in bits 63:62 and the port mask in bits 68:66. When it rewrites a matching entry, the new mask is ORed with the mask already stored.
- R10: Busy rises on the first clock edge after an accepted insert and stays high until the entry is written, for at most DEPTH+3 cycles.
- R11: A select-4 write sets the state of port wdata[9:8] to wdata[1:0] (0 disabled, 1 blocking, 2 learning, 3 forwarding). An index of NPORTS or more changes nothing. Port p appears at port_state[2p+1:2p].
- R12: A select-5 write with bit 0 set wipes every entry to zero, one entry per cycle, with busy high.
- R13: The wipe request has first claim, then ins_start, then a table-control command. A table-control command is dropped while busy or when it arrives in the same cycle as an accepted insert or wipe: neither the entry nor the data words change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0-2 data words, 3 table control, 4 port state, 5 wipe |
| cfg_wdata | input | 32 | Register write data |
| ins_start | input | 1 | Start an insert (ignored while busy) |
| ins_mcast | input | 1 | 1 for a multicast insert, 0 for unicast |
| ins_mac | input | 48 | MAC address to place |
| ins_port | input | 2 | Port number for a unicast insert |
| ins_secure | input | 1 | Secure flag for a unicast insert |
| ins_blocked | input | 1 | Blocked flag for a unicast insert |
| ins_mask | input | NPORTS | Port mask for a multicast insert |
| data_word0 | output | 32 | Data word 0 (entry bits 68:64, zero-extended) |
| data_word1 | output | 32 | Data word 1 (entry bits 63:32) |
| data_word2 | output | 32 | Data word 2 (entry bits 31:0) |
| ins_busy | output | 1 | Insert or wipe in progress |
| ins_fail | output | 1 | Last insert found no slot |
| port_state | output | 2*NPORTS | Per-port forwarding state |

## Verification
The insert engine and the software access path share the single table port. A table-control command can therefore land in the same cycle as an insert start, or during a search. The bench raises ins_start and a select-3 store in the same cycle, and then issues another store while busy is high. It then reads the data words, which must still hold the values written before. It also reads every entry and compares it with a model built from the requirements. Only the entry chosen by the insert may differ from its earlier value.

// File: rtl/lut_pkg.sv
package lut_pkg;

  // Field positions inside a table entry; neighbours decode these.
  localparam int TYPE_LO   = 60;
  localparam int UTYPE_LO  = 62;
  localparam int SEC_BIT   = 64;
  localparam int BLK_BIT   = 65;
  localparam int PORT_LO   = 66;
  localparam int GROUP_BIT = 40;

  localparam logic [1:0] ET_FREE      = 2'd0;
  localparam logic [1:0] ET_ADDR      = 2'd1;
  localparam logic [1:0] ET_VLAN_ADDR = 2'd3;

  localparam logic [1:0] UT_PERSIST = 2'd0;
  localparam logic [1:0] UT_OUI     = 2'd2;
  localparam logic [1:0] MC_FWD_ALL = 2'd3;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SCAN,
    S_COMMIT,
    S_CLEAR
  } seq_state_t;

endpackage

// File: rtl/lut_mem.sv
module lut_mem #(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 69,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    q <= store[raddr];
  end

endmodule

// File: rtl/lut_portctl.sv
module lut_portctl #(
  parameter int NPORTS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [1:0]            idx,
  input  logic [1:0]            st,
  output logic [2*NPORTS-1:0]   state_o
);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) state_o[2*p +: 2] <= 2'd0;
      else if (we && idx == 2'(p)) state_o[2*p +: 2] <= st;
    end
  end

  // R11: no accepted write, no change
  a_r11_state_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && int'(idx) < NPORTS) |=> $stable(state_o));

endmodule

// File: rtl/lut_seq.sv
module lut_seq
  import lut_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int NPORTS  = 3,
  parameter int ENTRY_W = 69,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               clear_go,
  input  logic               mcast,
  input  logic [47:0]        mac,
  input  logic [1:0]         port,
  input  logic               secure,
  input  logic               blocked,
  input  logic [NPORTS-1:0]  mask,
  input  logic [ENTRY_W-1:0] mem_q,
  output logic               busy,
  output logic               fail,
  output logic [IDX_W-1:0]   rd_addr,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [ENTRY_W-1:0] wr_data
);

  seq_state_t          state;
  logic [IDX_W:0]      scan;
  logic                rd_vld;
  logic [IDX_W-1:0]    rd_idx;
  logic                mcast_q, sec_q, blk_q;
  logic [47:0]         mac_q;
  logic [1:0]          port_q;
  logic [NPORTS-1:0]   mask_q, hit_mask;
  logic                hit_v, free_v, evict_v;
  logic [IDX_W-1:0]    hit_idx, free_idx, evict_idx;

  // evaluation of the entry returned by the table
  logic [1:0] q_type, q_utype;
  logic       q_addr, q_match, q_free, q_evict;
  logic       q_unused;

  assign q_type   = mem_q[TYPE_LO +: 2];
  assign q_utype  = mem_q[UTYPE_LO +: 2];
  assign q_addr   = (q_type == ET_ADDR) || (q_type == ET_VLAN_ADDR);
  assign q_match  = q_addr && (mem_q[47:0] == mac_q);
  assign q_free   = (q_type == ET_FREE);
  assign q_evict  = q_addr && !mem_q[GROUP_BIT] &&
                    (q_utype != UT_PERSIST) && (q_utype != UT_OUI);
  assign q_unused = ^{mem_q[59:48], mem_q[SEC_BIT], mem_q[BLK_BIT]};

  assign busy    = (state != S_IDLE);
  assign rd_addr = scan[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_CLEAR;
      scan    <= '0;
      rd_vld  <= 1'b0;
      rd_idx  <= '0;
      fail    <= 1'b0;
      mcast_q <= 1'b0;
      mac_q   <= '0;
      port_q  <= '0;
      sec_q   <= 1'b0;
      blk_q   <= 1'b0;
      mask_q  <= '0;
      hit_v   <= 1'b0;
      free_v  <= 1'b0;
      evict_v <= 1'b0;
      hit_idx <= '0;
      free_idx <= '0;
      evict_idx <= '0;
      hit_mask <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (clear_go) begin
            scan  <= '0;
            state <= S_CLEAR;
          end else if (start) begin
            mcast_q <= mcast;
            mac_q   <= mac;
            port_q  <= port;
            sec_q   <= secure;
            blk_q   <= blocked;
            mask_q  <= mask;
            scan    <= '0;
            rd_vld  <= 1'b0;
            hit_v   <= 1'b0;
            free_v  <= 1'b0;
            evict_v <= 1'b0;
            fail    <= 1'b0;
            state   <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (scan < (IDX_W+1)'(DEPTH)) begin
            rd_vld <= 1'b1;
            rd_idx <= scan[IDX_W-1:0];
            scan   <= scan + 1'b1;
          end else begin
            rd_vld <= 1'b0;
          end
          if (rd_vld) begin
            if (!hit_v && q_match) begin
              hit_v    <= 1'b1;
              hit_idx  <= rd_idx;
              hit_mask <= mem_q[PORT_LO +: NPORTS];
            end
            if (!free_v && q_free) begin
              free_v   <= 1'b1;
              free_idx <= rd_idx;
            end
            if (!evict_v && q_evict) begin
              evict_v   <= 1'b1;
              evict_idx <= rd_idx;
            end
            if (rd_idx == IDX_W'(DEPTH-1)) state <= S_COMMIT;
          end
        end
        S_COMMIT: begin
          if (!(hit_v || free_v || evict_v)) fail <= 1'b1;
          rd_vld <= 1'b0;
          state  <= S_IDLE;
        end
        default: begin
          scan <= scan + 1'b1;
          if (scan[IDX_W-1:0] == IDX_W'(DEPTH-1)) state <= S_IDLE;
        end
      endcase
    end
  end

  logic [ENTRY_W-1:0] new_entry;

  always_comb begin
    new_entry = '0;
    new_entry[TYPE_LO +: 2] = ET_ADDR;
    new_entry[47:0] = mac_q;
    if (mcast_q) begin
      new_entry[UTYPE_LO +: 2] = MC_FWD_ALL;
      new_entry[PORT_LO +: NPORTS] = mask_q | (hit_v ? hit_mask : '0);
    end else begin
      new_entry[UTYPE_LO +: 2] = UT_PERSIST;
      new_entry[SEC_BIT]       = sec_q;
      new_entry[BLK_BIT]       = blk_q;
      new_entry[PORT_LO +: 2]  = port_q;
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = scan[IDX_W-1:0];
    wr_data = '0;
    if (state == S_CLEAR) begin
      wr_en = 1'b1;
    end else if (state == S_COMMIT) begin
      wr_en   = hit_v || free_v || evict_v;
      wr_addr = hit_v ? hit_idx : (free_v ? free_idx : evict_idx);
      wr_data = new_entry;
    end
  end

  // R10: busy run length bounded
  logic [IDX_W+2:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= '0;
    else busy_run <= busy_run + 1'b1;
  end

  a_r10_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_run <= (IDX_W+3)'(DEPTH + 3));

  a_r7_fail_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $fell(busy));

  a_r7_start_clears_fail: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && !clear_go) |=> !fail);

  a_r13_req_held: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(mac_q));

endmodule

// File: rtl/addr_lookup_table.sv
module addr_lookup_table #(
  parameter int DEPTH  = 16,
  parameter int NPORTS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [31:0]          cfg_wdata,
  input  logic                 ins_start,
  input  logic                 ins_mcast,
  input  logic [47:0]          ins_mac,
  input  logic [1:0]           ins_port,
  input  logic                 ins_secure,
  input  logic                 ins_blocked,
  input  logic [NPORTS-1:0]    ins_mask,
  output logic [31:0]          data_word0,
  output logic [31:0]          data_word1,
  output logic [31:0]          data_word2,
  output logic                 ins_busy,
  output logic                 ins_fail,
  output logic [2*NPORTS-1:0]  port_state
);

  localparam int IDX_W   = $clog2(DEPTH);
  localparam int ENTRY_W = (66 + NPORTS > 68) ? 66 + NPORTS : 68;
  localparam int HI_W    = ENTRY_W - 64;

  logic [HI_W-1:0]    w_hi;
  logic [31:0]        w_mid, w_lo;
  logic               rd_pend;
  logic [ENTRY_W-1:0] mem_q, mem_wdata, seq_wdata;
  logic [IDX_W-1:0]   mem_waddr, mem_raddr, seq_raddr, seq_waddr, cmd_idx;
  logic               mem_we, seq_we;
  logic               clear_go, tbl_go, tbl_wr_go, tbl_rd_go;
  logic               cfg_unused;

  assign cmd_idx    = cfg_wdata[IDX_W-1:0];
  assign cfg_unused = ^cfg_wdata;

  // priority: wipe, then insert, then software table access
  assign clear_go  = cfg_we && cfg_sel == 3'd5 && cfg_wdata[0] && !ins_busy;
  assign tbl_go    = cfg_we && cfg_sel == 3'd3 && !ins_busy && !ins_start && !clear_go;
  assign tbl_wr_go = tbl_go && cfg_wdata[31];
  assign tbl_rd_go = tbl_go && !cfg_wdata[31];

  assign mem_we    = seq_we || tbl_wr_go;
  assign mem_waddr = seq_we ? seq_waddr : cmd_idx;
  assign mem_wdata = seq_we ? seq_wdata : {w_hi, w_mid, w_lo};
  assign mem_raddr = ins_busy ? seq_raddr : cmd_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_hi    <= '0;
      w_mid   <= '0;
      w_lo    <= '0;
      rd_pend <= 1'b0;
    end else begin
      rd_pend <= tbl_rd_go;
      if (rd_pend) begin
        {w_hi, w_mid, w_lo} <= mem_q;
      end else if (cfg_we) begin
        case (cfg_sel)
          3'd0:    w_hi  <= cfg_wdata[HI_W-1:0];
          3'd1:    w_mid <= cfg_wdata;
          3'd2:    w_lo  <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign data_word0 = {{(32-HI_W){1'b0}}, w_hi};
  assign data_word1 = w_mid;
  assign data_word2 = w_lo;

  lut_mem #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .q     (mem_q)
  );

  lut_seq #(.DEPTH(DEPTH), .NPORTS(NPORTS), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (ins_start),
    .clear_go (clear_go),
    .mcast    (ins_mcast),
    .mac      (ins_mac),
    .port     (ins_port),
    .secure   (ins_secure),
    .blocked  (ins_blocked),
    .mask     (ins_mask),
    .mem_q    (mem_q),
    .busy     (ins_busy),
    .fail     (ins_fail),
    .rd_addr  (seq_raddr),
    .wr_en    (seq_we),
    .wr_addr  (seq_waddr),
    .wr_data  (seq_wdata)
  );

  lut_portctl #(.NPORTS(NPORTS)) u_ports (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we && cfg_sel == 3'd4),
    .idx     (cfg_wdata[9:8]),
    .st      (cfg_wdata[1:0]),
    .state_o (port_state)
  );

  // R13: a table-control command while busy leaves the data words alone
  a_r13_cmd_dropped: assert property (@(posedge clk) disable iff (rst)
    (ins_busy && cfg_we && cfg_sel == 3'd3) |=> $stable({w_hi, w_mid, w_lo}));

  // R3: software never writes the table while the engine owns it
  a_r3_single_writer: assert property (@(posedge clk) disable iff (rst)
    seq_we |-> !tbl_wr_go);

endmodule

// File: tb/addr_lookup_table_bench.sv
module addr_lookup_table_bench;

  localparam int DEPTH  = 4;
  localparam int NPORTS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic ins_start = 1'b0, ins_mcast = 1'b0, ins_secure = 1'b0, ins_blocked = 1'b0;
  logic [47:0] ins_mac = '0;
  logic [1:0] ins_port = '0;
  logic [NPORTS-1:0] ins_mask = '0;
  logic [31:0] data_word0, data_word1, data_word2;
  logic ins_busy, ins_fail;
  logic [2*NPORTS-1:0] port_state;

  int checks = 0;
  int errors = 0;
  logic [68:0] model [DEPTH];

  always #5 clk = ~clk;

  addr_lookup_table #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u_addr_lookup_table (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ins_start(ins_start), .ins_mcast(ins_mcast), .ins_mac(ins_mac), .ins_port(ins_port),
    .ins_secure(ins_secure), .ins_blocked(ins_blocked), .ins_mask(ins_mask),
    .data_word0(data_word0), .data_word1(data_word1), .data_word2(data_word2),
    .ins_busy(ins_busy), .ins_fail(ins_fail), .port_state(port_state)
  );

  localparam logic [47:0] M1 = 48'h0200_0000_0001;
  localparam logic [47:0] M2 = 48'h0200_0000_0002;
  localparam logic [47:0] M3 = 48'h0200_0000_0003;
  localparam logic [47:0] M4 = 48'h0200_0000_0004;
  localparam logic [47:0] M5 = 48'h0200_0000_0005;
  localparam logic [47:0] M6 = 48'h0200_0000_0006;
  localparam logic [47:0] M7 = 48'h0200_0000_0007;
  localparam logic [47:0] MB = 48'hFFFF_FFFF_FFFF;

  // {mcast, mac, port, secure, blocked, mask, exp_fail, exp_idx, exp_mask}
  localparam int NV = 7;
  localparam logic [61:0] VECS [NV] = '{
    {1'b0, M1, 2'd1, 1'b1, 1'b0, 3'b000, 1'b0, 2'd0, 3'b000},
    {1'b1, MB, 2'd0, 1'b0, 1'b0, 3'b001, 1'b0, 2'd1, 3'b001},
    {1'b1, MB, 2'd0, 1'b0, 1'b0, 3'b100, 1'b0, 2'd1, 3'b101},
    {1'b0, M1, 2'd2, 1'b0, 1'b1, 3'b000, 1'b0, 2'd0, 3'b000},
    {1'b0, M2, 2'd0, 1'b0, 1'b0, 3'b000, 1'b0, 2'd2, 3'b000},
    {1'b0, M3, 2'd2, 1'b1, 1'b1, 3'b000, 1'b0, 2'd3, 3'b000},
    {1'b0, M4, 2'd1, 1'b0, 1'b0, 3'b000, 1'b1, 2'd0, 3'b000}
  };

  function automatic logic [68:0] exp_entry(input logic mc, input logic [47:0] mac,
      input logic [1:0] port, input logic sec, input logic blk, input logic [2:0] mask);
    logic [68:0] e;
    e = '0;
    e[61:60] = 2'd1;
    e[47:0] = mac;
    if (mc) begin
      e[63:62] = 2'd3;
      e[68:66] = mask;
    end else begin
      e[64] = sec;
      e[65] = blk;
      e[67:66] = port;
    end
    return e;
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_entry(input int idx, output logic [68:0] e);
    cfg_write(3'd3, 32'(idx));
    @(negedge clk);
    e = {data_word0[4:0], data_word1, data_word2};
  endtask

  task automatic write_entry(input int idx, input logic [68:0] e);
    cfg_write(3'd0, {27'd0, e[68:64]});
    cfg_write(3'd1, e[63:32]);
    cfg_write(3'd2, e[31:0]);
    cfg_write(3'd3, 32'h8000_0000 | 32'(idx));
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    while (ins_busy && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic do_insert(input logic mc, input logic [47:0] mac, input logic [1:0] port,
      input logic sec, input logic blk, input logic [2:0] mask);
    int cnt;
    @(negedge clk);
    ins_start = 1'b1; ins_mcast = mc; ins_mac = mac; ins_port = port;
    ins_secure = sec; ins_blocked = blk; ins_mask = mask;
    @(negedge clk);
    ins_start = 1'b0;
    chk("R10 busy after start", 96'(ins_busy), 96'd1);
    wait_idle(cnt);
    chk("R10 busy length bound", 96'(cnt + 1 <= DEPTH + 3), 96'd1);
  endtask

  task automatic check_table(input string tag);
    logic [68:0] e;
    for (int i = 0; i < DEPTH; i++) begin
      read_entry(i, e);
      chk(tag, 96'(e), 96'(model[i]));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int cnt;
    logic [68:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: wipe after reset
    chk("R1 busy during reset wipe", 96'(ins_busy), 96'd1);
    chk("R1 fail at reset", 96'(ins_fail), 96'd0);
    chk("R1 port state at reset", 96'(port_state), 96'd0);
    chk("R1 words at reset", {data_word0, data_word1, data_word2}, 96'd0);
    wait_idle(cnt);
    chk("R1 wipe length", 96'(cnt + 1), 96'(DEPTH));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    check_table("R1 table free after reset");

    // R2: data word access and word-0 width
    cfg_write(3'd0, 32'hFFFF_FFFF);
    cfg_write(3'd1, 32'h1234_5678);
    cfg_write(3'd2, 32'h9ABC_DEF0);
    chk("R2 data words", {data_word0, data_word1, data_word2},
        {32'h0000_001F, 32'h1234_5678, 32'h9ABC_DEF0});

    // R3: store and load round trip
    cfg_write(3'd3, 32'h8000_0003);
    cfg_write(3'd1, 32'd0);
    read_entry(3, e);
    chk("R3 load after store", 96'(e), {27'd0, 5'h1F, 32'h1234_5678, 32'h9ABC_DEF0});
    model[3] = {5'h1F, 32'h1234_5678, 32'h9ABC_DEF0};
    write_entry(3, 69'd0);
    model[3] = '0;

    // R4 R5 R8 R9 R7: vector walk
    for (int v = 0; v < NV; v++) begin
      logic [61:0] x;
      x = VECS[v];
      do_insert(x[61], x[60:13], x[12:11], x[10], x[9], x[8:6]);
      chk("R7 fail flag per vector", 96'(ins_fail), 96'(x[5]));
      if (!x[5]) model[x[4:3]] = exp_entry(x[61], x[60:13], x[12:11], x[10], x[9], x[2:0]);
      check_table("R4 R5 R8 R9 table after insert");
    end

    // R6: eviction order
    e = model[0]; e[63:62] = 2'd2; write_entry(0, e); model[0] = e;
    e = model[2]; e[63:62] = 2'd1; write_entry(2, e); model[2] = e;
    e = model[3]; e[63:62] = 2'd3; write_entry(3, e); model[3] = e;
    do_insert(1'b0, M5, 2'd1, 1'b0, 1'b0, 3'b000);
    chk("R6 evict untouched", 96'(ins_fail), 96'd0);
    model[2] = exp_entry(1'b0, M5, 2'd1, 1'b0, 1'b0, 3'b000);
    do_insert(1'b0, M6, 2'd2, 1'b1, 1'b0, 3'b000);
    model[3] = exp_entry(1'b0, M6, 2'd2, 1'b1, 1'b0, 3'b000);
    check_table("R6 table after evictions");
    do_insert(1'b0, M7, 2'd0, 1'b0, 1'b0, 3'b000);
    chk("R7 no evictable left", 96'(ins_fail), 96'd1);
    check_table("R7 table unchanged on fail");

    // R13: command collides with insert start, then arrives while busy
    cfg_write(3'd0, 32'h0000_000A);
    cfg_write(3'd1, 32'hCAFE_0000);
    cfg_write(3'd2, 32'h0000_BEEF);
    @(negedge clk);
    ins_start = 1'b1; ins_mcast = 1'b0; ins_mac = M1; ins_port = 2'd3;
    ins_secure = 1'b0; ins_blocked = 1'b0; ins_mask = '0;
    cfg_we = 1'b1; cfg_sel = 3'd3; cfg_wdata = 32'h8000_0001;
    @(negedge clk);
    ins_start = 1'b0;
    cfg_wdata = 32'h8000_0002;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_idle(cnt);
    chk("R7 fail cleared by next insert", 96'(ins_fail), 96'd0);
    chk("R13 words untouched", {data_word0, data_word1, data_word2},
        {32'h0000_000A, 32'hCAFE_0000, 32'h0000_BEEF});
    model[0] = exp_entry(1'b0, M1, 2'd3, 1'b0, 1'b0, 3'b000);
    check_table("R13 only insert target changed");

    // R11: port states
    cfg_write(3'd4, 32'h0000_0203);
    cfg_write(3'd4, 32'h0000_0102);
    cfg_write(3'd4, 32'h0000_0301);
    chk("R11 port states", 96'(port_state), 96'(6'b11_10_00));

    // R12: wipe, then an insert lands at index 0
    cfg_write(3'd5, 32'd1);
    chk("R12 busy during wipe", 96'(ins_busy), 96'd1);
    wait_idle(cnt);
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    check_table("R12 table wiped");
    do_insert(1'b1, MB, 2'd0, 1'b0, 1'b0, 3'b010);
    model[0] = exp_entry(1'b1, MB, 2'd0, 1'b0, 1'b0, 3'b010);
    check_table("R5 R9 insert after wipe");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule